// File: doc/BRIEF.md
# GPIO Edge-Interrupt Controller

This block holds the per-pin control state for a bank of general-purpose I/O lines and turns pin activity into one shared interrupt request. For each pin it keeps a direction bit, an output level, a three-state enable, a pull-up enable, an input inversion bit, an interrupt enable and two edge-select bits. These values drive the pad-side control outputs. Each incoming pin passes through a synchronizer and a run-length qualifier before it reaches the input register.

Edge detection compares each qualified pin level with a snapshot. The snapshot is taken at reset and again every time the host reads the input register, which the host signals with a one-cycle strobe. An event is pending while the level differs from the snapshot in a direction the pin has selected. An event therefore goes away in two ways: the pin returns to its old level, or the host reads the input register. The interrupt output is an open-drain pull-low enable. It is active while any enabled pin has an event pending.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are selected by `reg_addr`, and `reg_rdata` shows the selected register combinationally. The addresses are: input 0, output level 1, direction 2, three-state 3, pull-up 4, inversion 5, interrupt enable 6, rising select 7, falling select 8. Bit i of each register belongs to pin i. A write to address 0 has no effect, and reading any unused address returns zero.
- R2: Reset state:
  - every pin is an input (`pad_drv` all zero);
  - the output level, direction, three-state, inversion, interrupt enable and both edge-select registers are zero;
  - `irq_pull` is low.
- R3: `pad_drv[i]` is 1 exactly when direction bit i is 1 (output) and three-state bit i is 0. `pad_lvl` equals the output level register.
- R4: Bit i of the input register is the qualified level of pin i, XORed with inversion bit i.
- R5: The qualified level of a pin takes a new value only after `FILT_N` consecutive synchronized samples that differ from it. A pulse shorter than `FILT_N` clock cycles is ignored.
- R6: The snapshot is zero after reset. It loads the qualified levels on every clock edge at which `in_rd` is high, and holds its value otherwise.
- R7: Pin i has an event pending when one of these holds:
  - rising select bit i is set, the level is 1 and the snapshot is 0;
  - falling select bit i is set, the level is 0 and the snapshot is 1.
  Setting both bits selects both edges. A pending event clears, with no read, when the level returns to the snapshot value.
- R8: An `in_rd` strobe clears all pending events from the next cycle, even while the pins stay at their new levels.
- R9: `irq_pull` is 1 exactly when some pin with interrupt enable 1 has an event pending. Events on pins whose enable is 0 have no effect on it.
- R10: `pad_pull` equals the pull-up register. The reset value of every bit of that register is the parameter `PULL_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NPIN | Raw pin levels from the pads |
| pad_drv | output | NPIN | Per-pin output driver enable |
| pad_lvl | output | NPIN | Per-pin driven level |
| pad_pull | output | NPIN | Per-pin pull-up enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | NPIN | Register write data |
| reg_rdata | output | NPIN | Selected register contents |
| in_rd | input | 1 | Host read of the input register (one cycle) |
| irq_pull | output | 1 | Interrupt line pull-low enable (1 = line low) |

## Verification
The bench builds the block with the default sixteen pins, a qualifier length of four samples and pull-ups on at reset. The reset check therefore sees a non-zero pull-up pattern. The short qualifier makes it possible to compare a three-cycle pulse with a four-cycle pulse directly, which exercises the exact rejection threshold. With sixteen pins, random enable and edge-select masks mix enabled and disabled pins in one interrupt term, and the inversion mask lets the bench tell the input-register path apart from the edge path.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned RA_W = 4;

  typedef enum logic [RA_W-1:0] {
    RA_IN   = 4'd0,
    RA_OUT  = 4'd1,
    RA_DIR  = 4'd2,
    RA_HIZ  = 4'd3,
    RA_PULL = 4'd4,
    RA_INV  = 4'd5,
    RA_IEN  = 4'd6,
    RA_RISE = 4'd7,
    RA_FALL = 4'd8
  } reg_sel_e;

  // Event test for one pin: level against snapshot, gated by the edge selects.
  function automatic logic edge_pending(input logic lvl, input logic snap,
                                        input logic rise_en, input logic fall_en);
    return (lvl & ~snap & rise_en) | (~lvl & snap & fall_en);
  endfunction

  // Driver enable for one pin: output mode and not three-stated.
  function automatic logic drive_enable(input logic is_out, input logic hiz);
    return is_out & ~hiz;
  endfunction

endpackage

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int unsigned FILT_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_N + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_N - 1);

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      run_q  <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (s2_q == filt_q) begin
        run_q <= '0;
      end else if (run_q == CNT_LAST) begin
        filt_q <= s2_q;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign sync_o = s2_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN     = 16,
  parameter bit          PULL_RST = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [RA_W-1:0] addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] out_q,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] hiz_q,
  output logic [NPIN-1:0] pull_q,
  output logic [NPIN-1:0] inv_q,
  output logic [NPIN-1:0] ien_q,
  output logic [NPIN-1:0] rise_q,
  output logic [NPIN-1:0] fall_q
);
  localparam logic [NPIN-1:0] PULL_INIT = {NPIN{PULL_RST}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      hiz_q  <= '0;
      pull_q <= PULL_INIT;
      inv_q  <= '0;
      ien_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr) begin
      case (reg_sel_e'(addr))
        RA_OUT:  out_q  <= wdata;
        RA_DIR:  dir_q  <= wdata;
        RA_HIZ:  hiz_q  <= wdata;
        RA_PULL: pull_q <= wdata;
        RA_INV:  inv_q  <= wdata;
        RA_IEN:  ien_q  <= wdata;
        RA_RISE: rise_q <= wdata;
        RA_FALL: fall_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_track.sv
module gpio_edge_track
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  output logic [NPIN-1:0] snap_o,
  output logic [NPIN-1:0] pend_o
);
  logic [NPIN-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (rd_stb) snap_q <= lvl;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pend
    assign pend_o[i] = edge_pending(lvl[i], snap_q[i], rise_en[i], fall_en[i]);
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN     = 16,
  parameter int unsigned FILT_N   = 4,
  parameter bit          PULL_RST = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_drv,
  output logic [NPIN-1:0] pad_lvl,
  output logic [NPIN-1:0] pad_pull,
  input  logic            reg_wr,
  input  logic [3:0]      reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  input  logic            in_rd,
  output logic            irq_pull
);
  logic [NPIN-1:0] out_w, dir_w, hiz_w, pull_w, inv_w, ien_w, rise_w, fall_w;
  logic [NPIN-1:0] sync_w, filt_w, snap_w, pend_w, in_reg_w;
  logic            irq_any_w;

  gpio_cfg_regs #(.NPIN(NPIN), .PULL_RST(PULL_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .out_q(out_w), .dir_q(dir_w), .hiz_q(hiz_w), .pull_q(pull_w),
    .inv_q(inv_w), .ien_q(ien_w), .rise_q(rise_w), .fall_q(fall_w)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_pin_filter #(.FILT_N(FILT_N)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(pad_in[i]),
      .sync_o(sync_w[i]), .filt_o(filt_w[i])
    );
    assign pad_drv[i] = drive_enable(dir_w[i], hiz_w[i]);
  end

  gpio_edge_track #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .rd_stb(in_rd), .lvl(filt_w),
    .rise_en(rise_w), .fall_en(fall_w), .snap_o(snap_w), .pend_o(pend_w)
  );

  assign in_reg_w  = filt_w ^ inv_w;
  assign irq_any_w = |(pend_w & ien_w);
  assign irq_pull  = irq_any_w;
  assign pad_lvl   = out_w;
  assign pad_pull  = pull_w;

  always_comb begin
    case (reg_sel_e'(reg_addr))
      RA_IN:   reg_rdata = in_reg_w;
      RA_OUT:  reg_rdata = out_w;
      RA_DIR:  reg_rdata = dir_w;
      RA_HIZ:  reg_rdata = hiz_w;
      RA_PULL: reg_rdata = pull_w;
      RA_INV:  reg_rdata = inv_w;
      RA_IEN:  reg_rdata = ien_w;
      RA_RISE: reg_rdata = rise_w;
      RA_FALL: reg_rdata = fall_w;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int unsigned NPIN = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_rd,
  input logic            irq_pull,
  input logic [NPIN-1:0] pad_drv,
  input logic [NPIN-1:0] dir_w,
  input logic [NPIN-1:0] ien_w,
  input logic [NPIN-1:0] sync_w,
  input logic [NPIN-1:0] filt_w,
  input logic [NPIN-1:0] snap_w,
  input logic [NPIN-1:0] pend_w
);
  assert_reset_no_drive_R2: assert property (@(posedge clk)
    !rst_n |=> pad_drv == '0);

  assert_input_never_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drv & ~dir_w) == '0);

  assert_filter_follows_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_w ^ $past(filt_w)) & (filt_w ^ $past(sync_w))) == '0);

  assert_snap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |=> snap_w == $past(filt_w));

  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rd |=> $stable(snap_w));

  assert_pend_needs_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w & ~(filt_w ^ snap_w)) == '0);

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> (ien_w != '0));
endmodule

bind gpio_irq_ctrl gpio_irq_checker #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_rd(in_rd), .irq_pull(irq_pull),
  .pad_drv(pad_drv), .dir_w(dir_w), .ien_w(ien_w), .sync_w(sync_w),
  .filt_w(filt_w), .snap_w(snap_w), .pend_w(pend_w)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int unsigned NPIN   = 16;
  localparam int unsigned FILT_N = 4;
  localparam int unsigned SETTLE = FILT_N + 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_drv, pad_lvl, pad_pull, reg_rdata;
  logic            reg_wr = 1'b0;
  logic [3:0]      reg_addr = '0;
  logic [NPIN-1:0] reg_wdata = '0;
  logic            in_rd = 1'b0;
  logic            irq_pull;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench-side model state
  logic [NPIN-1:0] m_snap = '0, m_inv = '0, m_ien = '0, m_rise = '0, m_fall = '0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NPIN(NPIN), .FILT_N(FILT_N), .PULL_RST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_drv(pad_drv),
    .pad_lvl(pad_lvl), .pad_pull(pad_pull), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_rd(in_rd), .irq_pull(irq_pull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NPIN-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NPIN-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic strobe_read();
    @(negedge clk);
    in_rd = 1'b1;
    @(negedge clk);
    in_rd = 1'b0;
    m_snap = pad_in;
  endtask

  task automatic settle();
    for (int k = 0; k < SETTLE; k++) @(negedge clk);
  endtask

  // expected interrupt, walked pin by pin
  function automatic logic exp_irq(input logic [NPIN-1:0] lv, input logic [NPIN-1:0] sn);
    logic r = 1'b0;
    for (int i = 0; i < NPIN; i++) begin
      if (m_ien[i]) begin
        if (lv[i] && !sn[i] && m_rise[i]) r = 1'b1;
        if (!lv[i] && sn[i] && m_fall[i]) r = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic pulse_seen(input int width, output bit seen);
    seen = 1'b0;
    @(negedge clk);
    pad_in[0] = 1'b1;
    for (int k = 0; k < 20; k++) begin
      if (k == width - 1) begin
        @(negedge clk);
        pad_in[0] = 1'b0;
      end else begin
        @(negedge clk);
      end
      if (irq_pull) seen = 1'b1;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NPIN-1:0] d;
    logic [NPIN-1:0] dir, hiz, outv, pull;
    bit seen;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    #1;
    // R2 / R10: reset state
    chk("R2 drv at reset", 32'(pad_drv), 32'h0);
    chk("R10 pull at reset", 32'(pad_pull), 32'hFFFF);
    chk("R2 irq at reset", 32'(irq_pull), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(4'd2, d); chk("R2 dir reset", 32'(d), 32'h0);
    rd(4'd6, d); chk("R2 ien reset", 32'(d), 32'h0);
    rd(4'd7, d); chk("R2 rise reset", 32'(d), 32'h0);
    rd(4'd8, d); chk("R2 fall reset", 32'(d), 32'h0);

    // R3 / R10: pad controls
    dir = 16'hF0F3; hiz = 16'h3311; outv = 16'hA5C3; pull = 16'h0FF0;
    wr(4'd2, dir); wr(4'd3, hiz); wr(4'd1, outv); wr(4'd4, pull);
    @(negedge clk);
    chk("R3 drive enable", 32'(pad_drv), 32'(dir & ~hiz));
    chk("R3 drive level", 32'(pad_lvl), 32'(outv));
    chk("R10 pull follows reg", 32'(pad_pull), 32'(pull));
    rd(4'd1, d); chk("R1 readback out", 32'(d), 32'(outv));

    // R1: unused address and write to input ignored
    wr(4'd12, 16'hFFFF);
    rd(4'd12, d); chk("R1 unused reads zero", 32'(d), 32'h0);
    pad_in = 16'h00FF; settle();
    wr(4'd0, 16'h1234);
    rd(4'd0, d); chk("R1 input write ignored", 32'(d), 32'h00FF);

    // R4: inversion
    m_inv = 16'h0F0F; wr(4'd5, m_inv);
    rd(4'd0, d); chk("R4 inverted input", 32'(d), 32'(16'h00FF ^ m_inv));

    // R7 / R8 directed: rising only on pin 3
    pad_in = '0; settle(); strobe_read();
    m_ien = 16'h0008; m_rise = 16'h0008; m_fall = '0;
    wr(4'd6, m_ien); wr(4'd7, m_rise); wr(4'd8, m_fall);
    @(negedge clk); pad_in[3] = 1'b1; settle();
    chk("R7 rising sets irq", 32'(irq_pull), 32'h1);
    @(negedge clk); pad_in[3] = 1'b0; settle();
    chk("R7 return clears irq", 32'(irq_pull), 32'h0);
    @(negedge clk); pad_in[3] = 1'b1; settle();
    strobe_read();
    chk("R8 read clears irq", 32'(irq_pull), 32'h0);
    @(negedge clk); pad_in[3] = 1'b0; settle();
    chk("R7 falling not selected", 32'(irq_pull), 32'h0);
    m_fall = 16'h0008; wr(4'd8, m_fall);
    @(negedge clk); #1;
    chk("R7 falling selected", 32'(irq_pull), 32'h1);
    // R9: disabled pin events
    m_ien = 16'hFFF7; wr(4'd6, m_ien);
    @(negedge clk); #1;
    chk("R9 disabled pin masked", 32'(irq_pull), 32'h0);

    // R5: pulse widths around the qualifier length
    strobe_read();
    m_ien = 16'h0001; m_rise = 16'h0001; m_fall = '0;
    wr(4'd6, m_ien); wr(4'd7, m_rise); wr(4'd8, m_fall);
    pulse_seen(FILT_N - 1, seen);
    chk("R5 short pulse ignored", 32'(seen), 32'h0);
    pulse_seen(FILT_N, seen);
    chk("R5 full pulse accepted", 32'(seen), 32'h1);
    chk("R7 pulse ends clear", 32'(irq_pull), 32'h0);

    // random mix: R4, R7, R8, R9
    for (int it = 0; it < 30; it++) begin
      m_inv  = NPIN'($urandom); m_ien = NPIN'($urandom);
      m_rise = NPIN'($urandom); m_fall = NPIN'($urandom);
      wr(4'd5, m_inv); wr(4'd6, m_ien); wr(4'd7, m_rise); wr(4'd8, m_fall);
      @(negedge clk);
      pad_in = NPIN'($urandom);
      settle();
      rd(4'd0, d); chk("R4 random input", 32'(d), 32'(pad_in ^ m_inv));
      chk("R9 random irq", 32'(irq_pull), 32'(exp_irq(pad_in, m_snap)));
      if (it % 2 == 1) begin
        strobe_read();
        chk("R8 random read clears", 32'(irq_pull), 32'h0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule